// File: doc/BRIEF.md
# Per-Region Wait-State Generator

This block lengthens external bus cycles so that slow memory and I/O devices can keep up. Each register bank holds a 16-bit region configuration word and a one-bit doubling control. The configuration word carries a 3-bit wait count for each of five regions and an extended-program flag. The five regions are program low, program high, data low, data high, and I/O. When an access request arrives, the block looks up the region from the address and the space type. It scales the programmed count by 1 or 2 and never lets the count fall below one. It then holds `acc_ready` low for that many cycles.

Two register banks are provided. A bank-select input decides which bank governs the shared bus. The choice is fixed at the moment an access is accepted. Software reads and writes both banks through a simple register port. The wait count, the bank and the region are all captured when the access is accepted. A register write during an access therefore changes only later accesses.

Top module: `waitgen_top`

## Requirements
- R1: After reset, the configuration word of every bank reads 16'h7FFF, so all five fields are 7 and bit 15 is 0. The control word reads 0, which means factor 1.
- R2: A write with `cfg_sel`=0 stores all 16 bits into the configuration word of bank `cfg_bank`. A write with `cfg_sel`=1 stores only bit 0, the doubling bit, and the control word always reads with bits 15:1 at zero.
- R3: The configuration fields sit at these bit positions: program low bits 2:0, program high 5:3, data low 8:6, data high 11:9, I/O 14:12. When bit 15 is 0, a program access (`acc_space`=0) uses program high if address bit 15 is 1 and program low otherwise. Address bits above 15 are ignored in this case.
- R4: When bit 15 is 1, a program access uses program high whenever the full address is at or above 8000h. This holds even if address bit 15 is 0. Data accesses are not affected by the flag.
- R5: A data access (`acc_space`=1) uses data high if address bit 15 is 1 and data low otherwise. An access with `acc_space`=2 or 3 uses the I/O field whatever the address.
- R6: With the doubling bit set, the wait count is twice the selected field. A field of 7 gives 14.
- R7: The wait count is never below one, even when the product of field and factor is 0.
- R8: `acc_ready` is high while idle. After an accepted request it is low for exactly the wait count, and it goes high on the following cycle.
- R9: A request made while `acc_ready` is low is ignored. It neither changes the current count nor starts a later access.
- R10: A register write made during an access does not change that access. The next access uses the new value.
- R11: `bank_sel`, sampled when a request is accepted, chooses which bank's words set the wait count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_bank | input | 1 | Bank addressed by the register port |
| cfg_sel | input | 1 | 0 = configuration word, 1 = control word |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Read data of the addressed word |
| bank_sel | input | 1 | Bank that governs bus accesses |
| acc_req | input | 1 | Access request, taken when idle |
| acc_space | input | 2 | 0 program, 1 data, 2 or 3 I/O |
| acc_addr | input | 20 | Access address |
| acc_ready | output | 1 | Low while wait states are inserted |

## Verification
The assertions check the timing on every cycle. An accepted request must drop ready and load a count between 1 and 14. The count must fall by one per cycle. Ready must return high right after the last wait, and no request can be accepted while ready is low. Which field was chosen, and whether the doubling bit, the extended flag, the bank select and a mid-access write were honoured, can only be seen from the bench's scenarios. The bench measures the length of the low pulse at the ports and compares it with counts it computes from its own register model.

// File: rtl/waitgen_pkg.sv
package waitgen_pkg;
  localparam int FIELD_W   = 3;
  localparam int CFG_W     = 16;
  localparam int CNT_W     = 4;
  localparam int SPLIT_BIT = 15;
  localparam int EXT_BIT   = 15;

  typedef enum logic [2:0] {
    RG_PROG_LO = 3'd0,
    RG_PROG_HI = 3'd1,
    RG_DATA_LO = 3'd2,
    RG_DATA_HI = 3'd3,
    RG_IO      = 3'd4
  } region_e;

  typedef enum logic [1:0] {
    SP_PROG   = 2'd0,
    SP_DATA   = 2'd1,
    SP_IO     = 2'd2,
    SP_IO_ALT = 2'd3
  } space_e;

  // Pick the 3-bit field of one region out of the configuration word.
  function automatic logic [FIELD_W-1:0] field_of(logic [CFG_W-1:0] cfg, region_e r);
    return cfg[FIELD_W*int'(r) +: FIELD_W];
  endfunction

  // Scale by 1 or 2 and raise to at least one wait state.
  function automatic logic [CNT_W-1:0] eff_wait(logic [FIELD_W-1:0] f, logic dbl);
    logic [CNT_W-1:0] s;
    s = dbl ? {f, 1'b0} : {1'b0, f};
    return (s == '0) ? CNT_W'(1) : s;
  endfunction
endpackage

// File: rtl/waitgen_regbank.sv
module waitgen_regbank
  import waitgen_pkg::*;
#(
  parameter logic [CFG_W-1:0] RESET_CFG = 16'h7FFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [CFG_W-1:0] wr_data,
  output logic [CFG_W-1:0] cfg_q,
  output logic             dbl_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= RESET_CFG;
      dbl_q <= 1'b0;
    end else if (wr_en) begin
      if (wr_sel) dbl_q <= wr_data[0];
      else        cfg_q <= wr_data;
    end
  end
endmodule

// File: rtl/waitgen_decode.sv
module waitgen_decode
  import waitgen_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic [1:0]        space,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ext,
  output region_e           region
);
  logic prog_hi;
  logic unused_low_bits;

  assign unused_low_bits = ^addr[SPLIT_BIT-1:0];
  assign prog_hi = ext ? (|addr[ADDR_W-1:SPLIT_BIT]) : addr[SPLIT_BIT];

  always_comb begin
    unique case (space_e'(space))
      SP_PROG: region = prog_hi ? RG_PROG_HI : RG_PROG_LO;
      SP_DATA: region = addr[SPLIT_BIT] ? RG_DATA_HI : RG_DATA_LO;
      default: region = RG_IO;
    endcase
  end
endmodule

// File: rtl/waitgen_counter.sv
module waitgen_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] start_val,
  output logic             busy,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= start_val;
    end else if (busy) begin
      if (cnt == CNT_W'(1)) busy <= 1'b0;
      cnt <= cnt - CNT_W'(1);
    end
  end
endmodule

// File: rtl/waitgen_top.sv
module waitgen_top
  import waitgen_pkg::*;
#(
  parameter int               ADDR_W    = 20,
  parameter int               NUM_BANKS = 2,
  parameter logic [CFG_W-1:0] RESET_CFG = 16'h7FFF,
  localparam int              BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [BANK_W-1:0] cfg_bank,
  input  logic              cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic              acc_req,
  input  logic [1:0]        acc_space,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              acc_ready
);
  logic [CFG_W-1:0] cfg_all [NUM_BANKS];
  logic             dbl_all [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    waitgen_regbank #(.RESET_CFG(RESET_CFG)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_wr && (cfg_bank == BANK_W'(b))),
      .wr_sel  (cfg_sel),
      .wr_data (cfg_wdata),
      .cfg_q   (cfg_all[b]),
      .dbl_q   (dbl_all[b])
    );
  end

  assign cfg_rdata = cfg_sel ? {{(CFG_W-1){1'b0}}, dbl_all[cfg_bank]} : cfg_all[cfg_bank];

  // Named internal events for the checker.
  logic [CFG_W-1:0]   act_cfg;
  logic               act_dbl;
  region_e            region;
  logic [CNT_W-1:0]   load_val;
  logic               accept;
  logic               busy;
  logic [CNT_W-1:0]   cnt;

  assign act_cfg = cfg_all[bank_sel];
  assign act_dbl = dbl_all[bank_sel];

  waitgen_decode #(.ADDR_W(ADDR_W)) u_decode (
    .space  (acc_space),
    .addr   (acc_addr),
    .ext    (act_cfg[EXT_BIT]),
    .region (region)
  );

  assign load_val = eff_wait(field_of(act_cfg, region), act_dbl);
  assign accept   = acc_req && !busy;

  waitgen_counter #(.CNT_W(CNT_W)) u_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .start_val (load_val),
    .busy      (busy),
    .cnt       (cnt)
  );

  assign acc_ready = !busy;
endmodule

// File: rtl/waitgen_checker.sv
module waitgen_checker
  import waitgen_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             acc_req,
  input logic             acc_ready,
  input logic             accept,
  input logic             busy,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] load_val
);
  p_load_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (load_val >= CNT_W'(1) && load_val <= CNT_W'(14)));

  p_accept_drops_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!acc_ready && cnt == $past(load_val)));

  p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !accept && cnt > CNT_W'(1)) |=> (busy && cnt == $past(cnt) - CNT_W'(1)));

  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt == CNT_W'(1)) |=> acc_ready);

  p_no_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_ready |-> !accept);

  p_idle_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ready && !acc_req) |=> acc_ready);
endmodule

bind waitgen_top waitgen_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_req   (acc_req),
  .acc_ready (acc_ready),
  .accept    (accept),
  .busy      (busy),
  .cnt       (cnt),
  .load_val  (load_val)
);

// File: tb/test_waitgen_top.sv
`timescale 1ns/100ps
module test_waitgen_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic        cfg_bank = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        bank_sel = 1'b0;
  logic        acc_req = 1'b0;
  logic [1:0]  acc_space = '0;
  logic [19:0] acc_addr = '0;
  logic        acc_ready;

  int checks = 0;
  int errors = 0;
  logic [15:0] m_cfg [2];
  logic        m_dbl [2];

  always #2.5 clk = ~clk;

  waitgen_top i_waitgen_top (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_bank(cfg_bank),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .bank_sel(bank_sel), .acc_req(acc_req), .acc_space(acc_space),
    .acc_addr(acc_addr), .acc_ready(acc_ready)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_waits(input int b, input int sp, input int addr);
    int idx;
    int f;
    int n;
    if (sp >= 2) idx = 4;
    else if (sp == 1) idx = ((addr >> 15) & 1) ? 3 : 2;
    else if (m_cfg[b][15]) idx = (addr >= 'h8000) ? 1 : 0;
    else idx = ((addr >> 15) & 1) ? 1 : 0;
    f = (int'(m_cfg[b]) >> (3 * idx)) & 7;
    n = m_dbl[b] ? f * 2 : f;
    if (n < 1) n = 1;
    return n;
  endfunction

  task automatic wr_reg(input int b, input int sel, input int data);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_bank = b[0]; cfg_sel = sel[0]; cfg_wdata = data[15:0];
    @(negedge clk);
    cfg_wr = 1'b0;
    if (sel != 0) m_dbl[b] = data[0];
    else m_cfg[b] = data[15:0];
  endtask

  task automatic rd_check(input string tag, input int b, input int sel);
    @(negedge clk);
    cfg_bank = b[0]; cfg_sel = sel[0];
    #1;
    check(tag, int'(cfg_rdata), (sel != 0) ? int'(m_dbl[b]) : int'(m_cfg[b]));
  endtask

  task automatic start_req(input int b, input int sp, input int addr);
    @(negedge clk);
    check("R8 ready high when idle", int'(acc_ready), 1);
    acc_req = 1'b1; bank_sel = b[0]; acc_space = sp[1:0]; acc_addr = addr[19:0];
    @(negedge clk);
    acc_req = 1'b0;
  endtask

  task automatic count_lows(output int lows);
    lows = 0;
    while (!acc_ready && lows < 40) begin
      lows++;
      @(negedge clk);
    end
  endtask

  task automatic access(input string tag, input int b, input int sp, input int addr);
    int lows;
    int exp;
    exp = exp_waits(b, sp, addr);
    start_req(b, sp, addr);
    count_lows(lows);
    check(tag, lows, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lows;
    void'($urandom(32'd20240607));
    for (int b = 0; b < 2; b++) begin m_cfg[b] = 16'h7FFF; m_dbl[b] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    rd_check("R1 bank0 cfg", 0, 0);
    rd_check("R1 bank0 ctrl", 0, 1);
    rd_check("R1 bank1 cfg", 1, 0);
    rd_check("R1 bank1 ctrl", 1, 1);
    access("R1 R8 default seven waits", 0, 0, 'h100);

    // R2/R3/R5 distinct fields: 1,2,3,4,5
    wr_reg(0, 0, 'h58D1);
    rd_check("R2 cfg readback", 0, 0);
    access("R3 program low", 0, 0, 'h00010);
    access("R3 program high", 0, 0, 'h08000);
    access("R3 upper bits ignored", 0, 0, 'h10000);
    access("R5 data low", 0, 1, 'h00100);
    access("R5 data high", 0, 1, 'hF8000);
    access("R5 io", 0, 2, 'h00000);
    access("R5 io alt space", 0, 3, 'h08000);

    // R4 extended flag
    wr_reg(0, 0, 'hD8D1);
    access("R4 extended program high", 0, 0, 'h10000);
    access("R4 extended program low", 0, 0, 'h04000);
    access("R4 data unaffected", 0, 1, 'h10000);

    // R2 control word, R6 doubling, R7 minimum
    wr_reg(0, 1, 'hFFFF);
    rd_check("R2 ctrl only bit0", 0, 1);
    access("R6 doubled field", 0, 0, 'h00010);
    wr_reg(0, 0, 'h0000);
    access("R7 zero field doubled", 0, 2, 'h0);
    wr_reg(0, 1, 'h0000);
    access("R7 zero field", 0, 1, 'h0);
    wr_reg(0, 0, 'h7FFF);
    wr_reg(0, 1, 'h0001);
    access("R6 fourteen waits", 0, 1, 'h8000);

    // R11 bank select
    wr_reg(0, 0, 'h0000);
    wr_reg(0, 1, 'h0000);
    access("R11 bank1 governs", 1, 0, 'h0);
    access("R11 bank0 governs", 0, 0, 'h0);

    // R9 request while busy ignored
    start_req(1, 0, 'h0);
    acc_req = 1'b1; acc_space = 2'd1;
    @(negedge clk);
    acc_req = 1'b0;
    count_lows(lows);
    check("R9 busy request ignored", lows + 1, 7);
    @(negedge clk);
    check("R9 no queued access", int'(acc_ready), 1);

    // R10 write mid-access
    start_req(1, 1, 'h0);
    cfg_wr = 1'b1; cfg_bank = 1'b1; cfg_sel = 1'b0; cfg_wdata = 16'h0080;
    @(negedge clk);
    cfg_wr = 1'b0;
    count_lows(lows);
    check("R10 current access unchanged", lows + 1, 7);
    m_cfg[1] = 16'h0080;
    access("R10 next access uses new", 1, 1, 'h0);

    // Random mix
    for (int i = 0; i < 200; i++) begin
      int op;
      int b;
      op = $urandom_range(0, 9);
      b = $urandom_range(0, 1);
      if (op < 2) wr_reg(b, 0, int'($urandom & 32'hFFFF));
      else if (op < 3) wr_reg(b, 1, int'($urandom & 32'hFFFF));
      else if (op < 4) rd_check("R2 random readback", b, $urandom_range(0, 1));
      else access("R3 R4 R5 R6 R7 R11 random access", b, $urandom_range(0, 3),
                  int'($urandom & 32'hFFFFF));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule